// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz base-rate clock enable into a programmable periodic interrupt. A four-bit rate code picks the spacing between ticks, an enable input gates the generator, and a three-bit divider field can hold the counting chain in reset. Each tick raises a one-cycle pulse and sets two sticky flags, an interrupt-request flag and a periodic flag, which stay up until software reads them.

Phase is kept across a change of rate: when a new code is written, the base cycles that have already passed since the last tick count toward the next period. An optional compensation mode counts ticks that could not be delivered because the previous interrupt was still pending. That count is drained in two ways. A read of the flags can re-inject queued ticks back to back, up to a fixed limit between two real ticks. A catch-up timer can also deliver queued ticks at shorter intervals within a period.

All pins are plain control and status levels or single-cycle strobes. No data stream crosses the edge of the block, so it has no valid/ready handshake and no back-pressure.

Top module: `periodic_irq_gen`

## Requirements
- R1: The spacing between ticks, counted in accepted base strobes, is 256 for rate code 1, 128 for code 2 and 2^(code-1) for codes 3 to 15. `tick_o` is high for exactly one cycle, in the cycle after the base strobe that completes the period.
- R2: Every real tick sets both `irq_o` and `per_flag_o` in the same cycle that `tick_o` is high.
- R3: While `pie_en` is low or the rate code is 0, no tick occurs, the phase count returns to zero, and the missed-tick count reads 0 one cycle later.
- R4: While `div_ctl` is above 3'b010, no tick occurs and the phase count is cleared. After release, the first tick comes one full period of strobes later.
- R5: On a `rate_wr` strobe, if the elapsed count is below the new period, it is kept. The next tick comes when the elapsed count reaches the new period.
- R6: With `comp_en` low, a `rate_wr` strobe that finds the elapsed count at or above the new period schedules a tick on the next accepted base strobe.
- R7: With `comp_en` high, the same case adds floor(elapsed/new period) to the missed count and keeps elapsed mod new period as the phase.
- R8: With `comp_en` high, a real tick that arrives while `irq_o` is already high, and with no `flag_rd` in that cycle, increments the missed count. The count saturates at 2^MISS_W-1.
- R9: A `flag_rd` strobe clears both flags. If the missed count is non-zero, `pie_en` is high, no tick occurs in that cycle, and fewer than REINJ_MAX re-injections have happened since the last real tick, then both flags are set again instead and the missed count drops by one.
- R10: While the missed count m is non-zero, a catch-up slot fires every max(1, floor(period/(min(m,7)+1))) accepted strobes. The slot count restarts when m changes or a slot fires. A slot that finds `irq_o` low sets both flags and decrements m. A slot that finds `irq_o` high changes nothing. Slots never pulse `tick_o`.
- R11: After reset, `tick_o`, `irq_o` and `per_flag_o` are low and the missed count is 0.
- R12: A base strobe in the same cycle as `rate_wr` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_en | input | 1 | Base-rate clock enable, one cycle per 1/32768 s |
| rate_sel | input | 4 | Rate code; 0 turns the generator off |
| div_ctl | input | 3 | Divider control; values above 3'b010 hold the chain in reset |
| pie_en | input | 1 | Periodic interrupt enable |
| comp_en | input | 1 | Missed-tick compensation mode |
| rate_wr | input | 1 | Strobe: rate code or enable has just been rewritten |
| flag_rd | input | 1 | Strobe: flags are being read and cleared |
| tick_o | output | 1 | One-cycle pulse for each real tick |
| irq_o | output | 1 | Sticky interrupt-request flag |
| per_flag_o | output | 1 | Sticky periodic flag |
| miss_cnt_o | output | MISS_W | Count of ticks still owed |

## Verification
A phase counter that drifts shows up on `tick_o` at the very next tick. That tick lands one or more strobes early or late against the strobe index the scoreboard predicts, so an error in period decode or in rate-change carry is caught within one period. A wrong missed count is visible on `miss_cnt_o` in the cycle after a rate write, an undelivered tick, a read or a catch-up slot. A wrong re-injection limit shows on `irq_o` at the first read past the limit. Catch-up slots that fire at the wrong spacing change `irq_o` and `miss_cnt_o` within a few strobes, while `tick_o` stays untouched.

// File: rtl/pirg_pkg.sv
package pirg_pkg;
  localparam int PER_W  = 16;
  localparam int CODE_W = 4;

  typedef logic [PER_W-1:0]  per_t;
  typedef logic [CODE_W-1:0] code_t;

  // log2 of the tick spacing for a rate code
  function automatic code_t rate_shift(input code_t code);
    case (code)
      4'd0:    return 4'd0;
      4'd1:    return 4'd8;
      4'd2:    return 4'd7;
      default: return code - 4'd1;
    endcase
  endfunction

  function automatic per_t rate_period(input code_t code);
    if (code == '0) return '0;
    return per_t'(1) << rate_shift(code);
  endfunction
endpackage

// File: rtl/pirg_rate_decode.sv
module pirg_rate_decode
  import pirg_pkg::*;
(
  input  code_t      code_i,
  input  logic       pie_i,
  input  logic [2:0] div_i,
  output per_t       period_o,
  output code_t      shift_o,
  output logic       running_o
);
  always_comb begin
    period_o  = pie_i ? rate_period(code_i) : '0;
    shift_o   = rate_shift(code_i);
    running_o = (div_i <= 3'd2);
  end
endmodule

// File: rtl/pirg_phase.sv
module pirg_phase
  import pirg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe_i,
  input  logic  rate_wr_i,
  input  logic  comp_i,
  input  logic  active_i,
  input  per_t  period_i,
  input  code_t shift_i,
  output logic  tick_evt_o,
  output per_t  carry_o
);
  per_t           elapsed_q;
  logic [PER_W:0] elapsed_inc;
  logic           over;

  always_comb begin
    elapsed_inc = {1'b0, elapsed_q} + (PER_W+1)'(1);
    over        = (elapsed_q >= period_i);
    tick_evt_o  = active_i && strobe_i && !rate_wr_i &&
                  (elapsed_inc >= {1'b0, period_i});
    carry_o     = (active_i && rate_wr_i && over && comp_i) ?
                  (elapsed_q >> shift_i) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (!active_i) begin
      elapsed_q <= '0;
    end else if (rate_wr_i) begin
      if (over)
        elapsed_q <= comp_i ? (elapsed_q & (period_i - per_t'(1)))
                            : (period_i - per_t'(1));
    end else if (strobe_i) begin
      elapsed_q <= tick_evt_o ? '0 : elapsed_inc[PER_W-1:0];
    end
  end
endmodule

// File: rtl/pirg_slot.sv
module pirg_slot
  import pirg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_i,
  input  logic       rate_wr_i,
  input  logic       active_i,
  input  logic       miss_nz_i,
  input  logic       miss_chg_i,
  input  logic       block_i,
  input  per_t       period_i,
  input  logic [3:0] slots_i,
  output logic       slot_evt_o
);
  per_t           cnt_q;
  per_t           len;
  logic [PER_W:0] cnt_inc;
  logic           hit;

  always_comb begin
    len = period_i / per_t'(slots_i);
    if (len == '0) len = per_t'(1);
    cnt_inc    = {1'b0, cnt_q} + (PER_W+1)'(1);
    hit        = active_i && miss_nz_i && strobe_i && !rate_wr_i &&
                 (cnt_inc >= {1'b0, len});
    slot_evt_o = hit && !block_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!active_i || !miss_nz_i || miss_chg_i)
      cnt_q <= '0;
    else if (strobe_i && !rate_wr_i)
      cnt_q <= hit ? '0 : cnt_inc[PER_W-1:0];
  end
endmodule

// File: rtl/pirg_miss.sv
module pirg_miss
  import pirg_pkg::*;
#(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  input  per_t              add_i,
  input  logic              dec_i,
  output logic [MISS_W-1:0] miss_o,
  output logic              chg_o
);
  localparam int SUM_W = MISS_W + PER_W + 1;
  localparam logic [SUM_W-1:0] MAXV = SUM_W'({MISS_W{1'b1}});

  logic [MISS_W-1:0] miss_q, miss_d;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    sum = SUM_W'(miss_q) + SUM_W'(add_i) + SUM_W'(inc_i) - SUM_W'(dec_i);
    if (clr_i)          miss_d = '0;
    else if (sum > MAXV) miss_d = '1;
    else                 miss_d = sum[MISS_W-1:0];
    chg_o  = (miss_d != miss_q);
    miss_o = miss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= '0;
    else        miss_q <= miss_d;
  end

  // R8: a full counter never wraps toward zero
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_q == {MISS_W{1'b1}} && !clr_i) |=> (miss_q >= {MISS_W{1'b1}} - {{(MISS_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pirg_pkg::*;
#(
  parameter int MISS_W    = 16,
  parameter int REINJ_MAX = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_en,
  input  logic [3:0]        rate_sel,
  input  logic [2:0]        div_ctl,
  input  logic              pie_en,
  input  logic              comp_en,
  input  logic              rate_wr,
  input  logic              flag_rd,
  output logic              tick_o,
  output logic              irq_o,
  output logic              per_flag_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  localparam int BURST_W = $clog2(REINJ_MAX + 1);

  per_t               period;
  code_t              shift;
  logic               running, active, enabled;
  logic               tick_evt, slot_evt;
  per_t               carry;
  logic [MISS_W-1:0]  miss;
  logic               miss_chg, miss_nz;
  logic [3:0]         slots;
  logic               reinj, undelivered, slot_deliver, set_flags;
  logic               tick_q, irq_q, pf_q;
  logic [BURST_W-1:0] burst_q;

  pirg_rate_decode u_dec (
    .code_i(rate_sel), .pie_i(pie_en), .div_i(div_ctl),
    .period_o(period), .shift_o(shift), .running_o(running)
  );

  pirg_phase u_phase (
    .clk(clk), .rst_n(rst_n), .strobe_i(base_en), .rate_wr_i(rate_wr),
    .comp_i(comp_en), .active_i(active), .period_i(period), .shift_i(shift),
    .tick_evt_o(tick_evt), .carry_o(carry)
  );

  pirg_slot u_slot (
    .clk(clk), .rst_n(rst_n), .strobe_i(base_en), .rate_wr_i(rate_wr),
    .active_i(active), .miss_nz_i(miss_nz), .miss_chg_i(miss_chg),
    .block_i(tick_evt || flag_rd), .period_i(period), .slots_i(slots),
    .slot_evt_o(slot_evt)
  );

  pirg_miss #(.MISS_W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .clr_i(!enabled), .inc_i(undelivered),
    .add_i(carry), .dec_i(reinj || slot_deliver),
    .miss_o(miss), .chg_o(miss_chg)
  );

  always_comb begin
    enabled      = (period != '0);
    active       = enabled && running;
    miss_nz      = (miss != '0);
    slots        = (miss >= MISS_W'(7)) ? 4'd8 : ({1'b0, miss[2:0]} + 4'd1);
    reinj        = flag_rd && !tick_evt && miss_nz && pie_en &&
                   (burst_q < BURST_W'(REINJ_MAX));
    undelivered  = tick_evt && comp_en && irq_q && !flag_rd;
    slot_deliver = slot_evt && !irq_q;
    set_flags    = tick_evt || slot_deliver || reinj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= 1'b0;
      irq_q   <= 1'b0;
      pf_q    <= 1'b0;
      burst_q <= '0;
    end else begin
      tick_q <= tick_evt;
      if (set_flags) begin
        irq_q <= 1'b1;
        pf_q  <= 1'b1;
      end else if (flag_rd) begin
        irq_q <= 1'b0;
        pf_q  <= 1'b0;
      end
      if (tick_evt)   burst_q <= '0;
      else if (reinj) burst_q <= burst_q + BURST_W'(1);
    end
  end

  assign tick_o     = tick_q;
  assign irq_o      = irq_q;
  assign per_flag_o = pf_q;
  assign miss_cnt_o = miss;

  // R1: the shortest period is four strobes, so a tick never repeats at once
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R2: a tick is always seen with both flags up
  p_tick_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (irq_o && per_flag_o));
  // R3: an off generator is silent and owes nothing
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pie_en || rate_sel == 4'd0) |=> (!tick_o && miss_cnt_o == '0));
  // R4: divider hold suppresses ticks
  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl > 3'd2) |=> !tick_o);
  // R9: a read with nothing owed and no strobe leaves the flags low
  p_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !base_en && miss_cnt_o == '0) |=> (!irq_o && !per_flag_o));
  // R9: an eligible read re-injects one owed tick
  p_reinj_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !base_en && !rate_wr && pie_en && rate_sel != 4'd0 &&
     miss_cnt_o != '0 && burst_q < BURST_W'(REINJ_MAX))
    |=> (irq_o && miss_cnt_o == $past(miss_cnt_o) - {{(MISS_W-1){1'b0}}, 1'b1}));
  // R12: a rate write is never followed directly by a tick
  p_rate_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr |=> !tick_o);
endmodule

// File: tb/sim_periodic_irq_gen.sv
`timescale 1ns/1ps
module sim_periodic_irq_gen;
  localparam int MW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic base_en = 0, pie_en = 0, comp_en = 0, rate_wr = 0, flag_rd = 0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] div_ctl = 3'b010;
  logic tick_o, irq_o, per_flag_o;
  logic [MW-1:0] miss_cnt_o;

  int checks = 0, errors = 0, strobe_cnt = 0;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  periodic_irq_gen #(.MISS_W(MW), .REINJ_MAX(20)) u0 (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .rate_sel(rate_sel),
    .div_ctl(div_ctl), .pie_en(pie_en), .comp_en(comp_en), .rate_wr(rate_wr),
    .flag_rd(flag_rd), .tick_o(tick_o), .irq_o(irq_o),
    .per_flag_o(per_flag_o), .miss_cnt_o(miss_cnt_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts strobes seen at the edge, scores ticks against the queue
  always @(posedge clk) if (rst_n && base_en) strobe_cnt++;
  always @(negedge clk) begin
    if (rst_n && tick_o) begin
      if (exp_q.size() == 0) chk("R1 unexpected tick at strobe", strobe_cnt, -1);
      else chk("R1 tick strobe index", strobe_cnt, exp_q.pop_front());
    end
  end

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin base_en = 1; @(negedge clk); end
    base_en = 0;
  endtask
  task automatic expect_tick(int after);
    exp_q.push_back(strobe_cnt + after);
  endtask
  task automatic set_rate(logic [3:0] c);
    rate_sel = c; rate_wr = 1; @(negedge clk); rate_wr = 0;
  endtask
  task automatic reads(int n);
    flag_rd = 1; repeat (n) @(negedge clk); flag_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R11 tick", tick_o, 0); chk("R11 irq", irq_o, 0);
    chk("R11 pflag", per_flag_o, 0); chk("R11 miss", miss_cnt_o, 0);

    // R1 code 3: four strobes per tick; R2 flags
    rate_sel = 4'd3; pie_en = 1;
    expect_tick(4); expect_tick(8); expect_tick(12);
    strobes(12);
    chk("R2 irq after tick", irq_o, 1); chk("R2 pflag after tick", per_flag_o, 1);

    // R1 codes 1 and 2
    set_rate(4'd1); expect_tick(256); strobes(256);
    set_rate(4'd2); expect_tick(128); strobes(128);

    // R6 cap without compensation, R5 phase kept
    set_rate(4'd6); strobes(10);
    set_rate(4'd4); expect_tick(1); strobes(1);
    strobes(5);
    set_rate(4'd7); expect_tick(59); strobes(59);

    // R9 plain clear, R3 enable low
    reads(1);
    chk("R9 irq cleared", irq_o, 0); chk("R9 pflag cleared", per_flag_o, 0);
    pie_en = 0; strobes(80);
    chk("R3 no flag while disabled", irq_o, 0);
    pie_en = 1; expect_tick(64); strobes(64);
    set_rate(4'd0); strobes(100);
    set_rate(4'd3); expect_tick(4); strobes(4);

    // R4 divider hold clears the phase
    strobes(2);
    div_ctl = 3'b110; strobes(40);
    div_ctl = 3'b010; expect_tick(4); strobes(4);

    // R7 compensated rate change: 10 elapsed, new period 4
    comp_en = 1; reads(1);
    set_rate(4'd6); strobes(10);
    set_rate(4'd3);
    chk("R7 carried miss", miss_cnt_o, 2);
    expect_tick(2); strobes(2);
    pie_en = 0; @(negedge clk);
    chk("R3 miss cleared when disabled", miss_cnt_o, 0);

    // R8 accumulate and saturate (33 ticks, first delivered)
    reads(1);
    rate_sel = 4'd5; pie_en = 1;
    for (int k = 1; k <= 33; k++) expect_tick(16 * k);
    strobes(528);
    chk("R8 saturated miss", miss_cnt_o, 31);
    chk("R8 irq pending", irq_o, 1);

    // R9 twenty re-injections, then the limit
    reads(20);
    chk("R9 reinjected irq", irq_o, 1); chk("R9 reinjected pflag", per_flag_o, 1);
    chk("R9 miss after burst", miss_cnt_o, 11);
    reads(1);
    chk("R9 limit irq", irq_o, 0); chk("R9 limit pflag", per_flag_o, 0);
    chk("R9 limit miss", miss_cnt_o, 11);

    // R10 catch-up slots: period 16, 8 slots of 2 strobes
    strobes(2);
    chk("R10 slot delivered irq", irq_o, 1);
    chk("R10 slot decremented", miss_cnt_o, 10);
    strobes(2);
    chk("R10 slot blocked by pending irq", miss_cnt_o, 10);
    expect_tick(12); strobes(12);

    // R12 strobe during rate write is not counted
    rate_sel = 4'd5; rate_wr = 1; base_en = 1;
    exp_q.push_back(strobe_cnt + 1 + 16);
    @(negedge clk); rate_wr = 0; base_en = 0;
    strobes(16);

    repeat (4) @(negedge clk);
    chk("R1 all expected ticks seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule